// File: doc/BRIEF.md
# Fully Associative Fetch-Target Cache

This block is the storage behind the first stage of a branch predictor. It holds a small number of fetch-target entries. Each entry is an opaque payload that a later stage turns into a prediction. Every line keeps a 16-bit tag taken from PC bits [16:1] and has no set index. A lookup PC is compared against all lines at once. In the same cycle the block returns the matching entry, a hit flag and the index of the line that hit.

A separate update port installs an entry for a given PC over two clock edges. At the first edge the update tag is compared against every line and the result is latched. At the second edge the entry is written. It goes to the line that matched, or, if none did, to the line chosen by a binary-tree pseudo-LRU. Lookups and updates run in the same cycle without interfering. A registered metadata word reports the previous cycle's hit flag and way index, so that the later pipeline stages can steer training. An enable input suppresses hits without stopping updates.

Top module: `fa_ftc`

## Requirements
- R1: After reset no line is valid, so every lookup misses, and `meta_o` reads zero.
- R2: The lookup and update tags are PC bits [TAG_LSB+TAG_W-1:TAG_LSB], by default [16:1]. PC bits outside that field never change a lookup or update result.
- R3: In the cycle a lookup PC is presented with `lkp_valid_i` high, `lkp_hit_o` is high exactly when a valid line holds the tag. `lkp_way_o` and `lkp_entry_o` then give that line's index and stored entry. On a miss both read zero.
- R4: While `enable_i` is low, `lkp_hit_o`, `lkp_way_o` and `lkp_entry_o` are zero. Updates presented during that time are still installed.
- R5: An update presented in cycle t is not visible to a lookup in cycle t+1. It is visible to a lookup in cycle t+2 and afterwards.
- R6: An update whose tag is already held by a valid line rewrites that same line with the new entry.
- R7: An update whose tag is held by no line is written to the pseudo-LRU victim. The tree has N-1 node bits in heap order, with the root at node 1 and the children of node n at 2n and 2n+1. The victim walk starts at the root and at each node goes to child 2n+bit. All bits are zero after reset.
- R8: The tree is touched on every lookup hit and on every write. A touch of way w sets each node on w's path to point away from w. When both happen in one cycle, the write is applied last.
- R9: No two valid lines ever hold the same tag. This holds even when two updates of the same tag arrive in consecutive cycles. The second update reuses the line chosen for the first.
- R10: `meta_o` is the lookup hit flag in bit 0 and the lookup way in bits [WAY_W:1]. Both are registered one cycle after the lookup, and the upper bits are zero.
- R11: A lookup and an update in the same cycle are both served. The lookup sees the contents that were present before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Allows lookup hits when high |
| lkp_valid_i | input | 1 | Lookup request valid |
| lkp_pc_i | input | PC_W | Lookup PC |
| lkp_hit_o | output | 1 | Lookup hit, same cycle |
| lkp_way_o | output | WAY_W | Index of the line that hit |
| lkp_entry_o | output | ENTRY_W | Entry stored in the line that hit |
| upd_valid_i | input | 1 | Update request valid |
| upd_pc_i | input | PC_W | PC of the entry being installed |
| upd_entry_i | input | ENTRY_W | Entry payload to install |
| meta_o | output | META_W | Registered {zeros, way, hit} of the previous lookup |

## Verification
The bench runs an eight-line configuration against a cycle model of the tree and the lines.

- **Filling an empty cache** with distinct tags, each followed by lookups one and two cycles later. This separates the cycle an update becomes visible from the cycle before it.
- **Rewriting tags already held** and **back-to-back updates of one tag**. These separate reuse of the matching line from wrongly allocating a victim.
- **Sweeps of more tags than lines**, with lookup hits interleaved. These separate a correct tree walk and touch order from near misses.
- **Varying PC bits outside the tag field and disabled-enable stretches.** These show that only the tag field and the enable input gate a hit.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int unsigned FTC_WAYS    = 32;
  localparam int unsigned FTC_PC_W    = 41;
  localparam int unsigned FTC_TAG_W   = 16;
  localparam int unsigned FTC_TAG_LSB = 1;
  localparam int unsigned FTC_ENTRY_W = 64;
  localparam int unsigned FTC_META_W  = 32;
endpackage

// File: rtl/ftc_line.sv
module ftc_line #(
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned ENTRY_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TAG_W-1:0]   lkp_tag,
  input  logic [TAG_W-1:0]   upd_tag,
  input  logic               wr_en,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [ENTRY_W-1:0] wr_entry,
  output logic               lkp_hit,
  output logic               upd_hit,
  output logic               valid,
  output logic [ENTRY_W-1:0] entry
);
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else if (wr_en) valid <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q <= wr_tag;
      entry <= wr_entry;
    end
  end

  assign lkp_hit = valid && (tag_q == lkp_tag);
  assign upd_hit = valid && (tag_q == upd_tag);
endmodule

// File: rtl/ftc_prio_enc.sv
module ftc_prio_enc #(
  parameter int unsigned N = 32,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/ftc_plru.sv
module ftc_plru #(
  parameter int unsigned N = 32,
  localparam int unsigned WAY_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_a_en,
  input  logic [WAY_W-1:0] touch_a_way,
  input  logic             touch_b_en,
  input  logic [WAY_W-1:0] touch_b_way,
  output logic [WAY_W-1:0] victim
);
  logic [N-2:0] tree_q, tree_a, tree_b;

  function automatic logic [N-2:0] touch(input logic [N-2:0] t, input logic [WAY_W-1:0] w);
    logic [WAY_W:0] node;
    logic b;
    node = (WAY_W+1)'(1);
    for (int l = 0; l < WAY_W; l++) begin
      b = w[WAY_W-1-l];
      t[node-1] = ~b;
      node = {node[WAY_W-1:0], b};
    end
    return t;
  endfunction

  always_comb begin
    logic [WAY_W:0] node;
    logic b;
    node = (WAY_W+1)'(1);
    victim = '0;
    for (int l = 0; l < WAY_W; l++) begin
      b = tree_q[node-1];
      victim[WAY_W-1-l] = b;
      node = {node[WAY_W-1:0], b};
    end
  end

  assign tree_a = touch_a_en ? touch(tree_q, touch_a_way) : tree_q;
  assign tree_b = touch_b_en ? touch(tree_a, touch_b_way) : tree_a;

  always_ff @(posedge clk) begin
    if (rst) tree_q <= '0;
    else tree_q <= tree_b;
  end
endmodule

// File: rtl/fa_ftc.sv
module fa_ftc
  import ftc_pkg::*;
#(
  parameter int unsigned N_WAYS  = FTC_WAYS,
  parameter int unsigned PC_W    = FTC_PC_W,
  parameter int unsigned TAG_W   = FTC_TAG_W,
  parameter int unsigned TAG_LSB = FTC_TAG_LSB,
  parameter int unsigned ENTRY_W = FTC_ENTRY_W,
  parameter int unsigned META_W  = FTC_META_W,
  localparam int unsigned WAY_W  = $clog2(N_WAYS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable_i,
  input  logic               lkp_valid_i,
  input  logic [PC_W-1:0]    lkp_pc_i,
  output logic               lkp_hit_o,
  output logic [WAY_W-1:0]   lkp_way_o,
  output logic [ENTRY_W-1:0] lkp_entry_o,
  input  logic               upd_valid_i,
  input  logic [PC_W-1:0]    upd_pc_i,
  input  logic [ENTRY_W-1:0] upd_entry_i,
  output logic [META_W-1:0]  meta_o
);
  logic [TAG_W-1:0]   lkp_tag, upd_tag;
  logic [N_WAYS-1:0]  lkp_match, upd_match, line_valid;
  logic [ENTRY_W-1:0] line_entry [N_WAYS];
  logic               lkp_any, upd_any;
  logic [WAY_W-1:0]   lkp_idx, upd_idx, victim;

  // update pipeline stage between the search edge and the write edge
  logic               pend_v, pend_hit;
  logic [WAY_W-1:0]   pend_way;
  logic [TAG_W-1:0]   pend_tag;
  logic [ENTRY_W-1:0] pend_entry;
  logic               wr_en;
  logic [WAY_W-1:0]   wr_way;
  logic               fwd;

  logic               hit_r;
  logic [WAY_W-1:0]   way_r;

  assign lkp_tag = lkp_pc_i[TAG_LSB +: TAG_W];
  assign upd_tag = upd_pc_i[TAG_LSB +: TAG_W];

  for (genvar g = 0; g < N_WAYS; g++) begin : g_line
    ftc_line #(.TAG_W(TAG_W), .ENTRY_W(ENTRY_W)) line_i (
      .clk      (clk),
      .rst      (rst),
      .lkp_tag  (lkp_tag),
      .upd_tag  (upd_tag),
      .wr_en    (wr_en && (wr_way == WAY_W'(g))),
      .wr_tag   (pend_tag),
      .wr_entry (pend_entry),
      .lkp_hit  (lkp_match[g]),
      .upd_hit  (upd_match[g]),
      .valid    (line_valid[g]),
      .entry    (line_entry[g])
    );
  end

  ftc_prio_enc #(.N(N_WAYS)) lkp_enc_i (.vec(lkp_match), .any(lkp_any), .idx(lkp_idx));
  ftc_prio_enc #(.N(N_WAYS)) upd_enc_i (.vec(upd_match), .any(upd_any), .idx(upd_idx));

  assign lkp_hit_o   = lkp_valid_i && enable_i && lkp_any;
  assign lkp_way_o   = lkp_hit_o ? lkp_idx : '0;
  assign lkp_entry_o = lkp_hit_o ? line_entry[lkp_idx] : '0;

  assign wr_en  = pend_v;
  assign wr_way = pend_hit ? pend_way : victim;
  assign fwd    = pend_v && (pend_tag == upd_tag);

  ftc_plru #(.N(N_WAYS)) plru_i (
    .clk         (clk),
    .rst         (rst),
    .touch_a_en  (lkp_hit_o),
    .touch_a_way (lkp_idx),
    .touch_b_en  (wr_en),
    .touch_b_way (wr_way),
    .victim      (victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
    end else begin
      pend_v <= upd_valid_i;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_valid_i) begin
      pend_tag   <= upd_tag;
      pend_entry <= upd_entry_i;
      pend_hit   <= fwd || upd_any;
      pend_way   <= fwd ? wr_way : upd_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_r <= 1'b0;
      way_r <= '0;
    end else begin
      hit_r <= lkp_hit_o;
      way_r <= lkp_way_o;
    end
  end

  assign meta_o = META_W'({way_r, hit_r});
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
  parameter int unsigned N_WAYS  = 32,
  parameter int unsigned ENTRY_W = 64,
  parameter int unsigned META_W  = 32,
  localparam int unsigned WAY_W  = $clog2(N_WAYS)
) (
  input logic               clk,
  input logic               rst,
  input logic               enable_i,
  input logic               lkp_hit_o,
  input logic [WAY_W-1:0]   lkp_way_o,
  input logic [ENTRY_W-1:0] lkp_entry_o,
  input logic [META_W-1:0]  meta_o,
  input logic [N_WAYS-1:0]  match_vec,
  input logic [N_WAYS-1:0]  valid_vec,
  input logic               wr_en,
  input logic [WAY_W-1:0]   wr_way
);
  p_reset_meta_r1: assert property (@(posedge clk) rst |=> (meta_o == '0));
  p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !lkp_hit_o |-> (lkp_entry_o == '0 && lkp_way_o == '0));
  p_hit_line_r3: assert property (@(posedge clk) disable iff (rst)
    lkp_hit_o |-> match_vec[lkp_way_o]);
  p_disabled_r4: assert property (@(posedge clk) disable iff (rst)
    !enable_i |-> !lkp_hit_o);
  p_write_valid_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_vec[$past(wr_way)]);
  p_unique_tag_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));
  p_meta_hit_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (meta_o[0] == $past(lkp_hit_o)));
  p_meta_way_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (meta_o[WAY_W:1] == $past(lkp_way_o)));
endmodule

bind fa_ftc ftc_checker #(.N_WAYS(N_WAYS), .ENTRY_W(ENTRY_W), .META_W(META_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .enable_i    (enable_i),
  .lkp_hit_o   (lkp_hit_o),
  .lkp_way_o   (lkp_way_o),
  .lkp_entry_o (lkp_entry_o),
  .meta_o      (meta_o),
  .match_vec   (lkp_match),
  .valid_vec   (line_valid),
  .wr_en       (wr_en),
  .wr_way      (wr_way)
);

// File: tb/fa_ftc_tb_top.sv
module fa_ftc_tb_top;
  localparam int N = 8;
  localparam int WW = 3;
  localparam int PCW = 24;
  localparam int EW = 16;
  localparam int MW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable_i = 1'b1;
  logic lkp_valid_i = 1'b0;
  logic [PCW-1:0] lkp_pc_i = '0;
  logic upd_valid_i = 1'b0;
  logic [PCW-1:0] upd_pc_i = '0;
  logic [EW-1:0] upd_entry_i = '0;
  logic lkp_hit_o;
  logic [WW-1:0] lkp_way_o;
  logic [EW-1:0] lkp_entry_o;
  logic [MW-1:0] meta_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fa_ftc #(.N_WAYS(N), .PC_W(PCW), .TAG_W(16), .TAG_LSB(1), .ENTRY_W(EW), .META_W(MW)) dut_i (
    .clk(clk), .rst(rst), .enable_i(enable_i),
    .lkp_valid_i(lkp_valid_i), .lkp_pc_i(lkp_pc_i),
    .lkp_hit_o(lkp_hit_o), .lkp_way_o(lkp_way_o), .lkp_entry_o(lkp_entry_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_entry_i(upd_entry_i),
    .meta_o(meta_o)
  );

  // reference model state
  logic [15:0] mtag [N];
  bit          mval [N];
  logic [15:0] ment [N];
  logic [N-2:0] mtree;
  bit          p_v, p_hit;
  logic [WW-1:0] p_way;
  logic [15:0] p_tag, p_ent;
  logic [MW-1:0] m_meta;

  function automatic logic [N-2:0] m_touch(input logic [N-2:0] t, input int w);
    int node = 1;
    for (int l = 0; l < WW; l++) begin
      int b = (w >> (WW - 1 - l)) & 1;
      t[node-1] = (b == 0);
      node = 2 * node + b;
    end
    return t;
  endfunction

  function automatic int m_victim(input logic [N-2:0] t);
    int node = 1;
    int v = 0;
    for (int l = 0; l < WW; l++) begin
      int b = int'(t[node-1]);
      v = 2 * v + b;
      node = 2 * node + b;
    end
    return v;
  endfunction

  function automatic logic [PCW-1:0] mkpc(input logic [15:0] tag, input int junk);
    logic [PCW-1:0] p;
    p = '0;
    p[16:1] = tag;
    p[0] = junk[0];
    p[PCW-1:17] = 7'(junk >> 1);
    return p;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit lv, input logic [15:0] ltag, input int junk,
                      input bit uv, input logic [15:0] utag, input logic [15:0] uent,
                      input bit en, input string rq);
    bit eh = 0;
    int ew = 0;
    logic [15:0] ee = '0;
    int wway;
    bit nh;
    int nway;
    @(negedge clk);
    lkp_valid_i = lv; lkp_pc_i = mkpc(ltag, junk);
    upd_valid_i = uv; upd_pc_i = mkpc(utag, junk + 5); upd_entry_i = uent;
    enable_i = en;
    #1;
    if (lv && en) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (mval[i] && mtag[i] == ltag) begin eh = 1; ew = i; ee = ment[i]; end
      end
    end
    chk(rq, "hit", 32'(lkp_hit_o), 32'(eh));
    chk(rq, "way", 32'(lkp_way_o), 32'(ew));
    chk(rq, "entry", 32'(lkp_entry_o), 32'(ee));
    chk("R10", "meta", 32'(meta_o), 32'(m_meta));
    // next state of the model
    wway = p_hit ? int'(p_way) : m_victim(mtree);
    nh = 0; nway = 0;
    if (uv) begin
      if (p_v && p_tag == utag) begin nh = 1; nway = wway; end
      else begin
        for (int i = N - 1; i >= 0; i--) begin
          if (mval[i] && mtag[i] == utag) begin nh = 1; nway = i; end
        end
      end
    end
    if (eh) mtree = m_touch(mtree, ew);
    if (p_v) begin
      mval[wway] = 1; mtag[wway] = p_tag; ment[wway] = p_ent;
      mtree = m_touch(mtree, wway);
    end
    m_meta = MW'({WW'(ew), eh});
    if (uv) begin p_tag = utag; p_ent = uent; p_hit = nh; p_way = WW'(nway); end
    p_v = uv;
    @(posedge clk);
  endtask

  task automatic idle(input string rq);
    step(0, 16'h0, 0, 0, 16'h0, 16'h0, 1, rq);
  endtask

  function automatic logic [15:0] tg(input int i);
    return 16'((i * 16'h1357) ^ 16'hA5C3);
  endfunction

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mval[i] = 0; mtag[i] = '0; ment[i] = '0; end
    mtree = '0; p_v = 0; p_hit = 0; p_way = '0; p_tag = '0; p_ent = '0; m_meta = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: empty after reset
    step(1, tg(0), 0, 0, 16'h0, 16'h0, 1, "R1");
    step(1, 16'h0000, 3, 0, 16'h0, 16'h0, 1, "R1");
    // R7/R5/R3: fill from empty, visibility timing
    for (int i = 0; i < N; i++) begin
      step(0, 16'h0, 0, 1, tg(i), 16'(16'h100 + i), 1, "R7");
      step(1, tg(i), i, 0, 16'h0, 16'h0, 1, "R5");
      step(1, tg(i), i + 9, 0, 16'h0, 16'h0, 1, "R3");
    end
    // R2: PC bits outside the tag field do not matter
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < 4; j++) step(1, tg(i), j * 37 + 1, 0, 16'h0, 16'h0, 1, "R2");
    end
    // R4: disabled lookups miss, update still lands
    step(1, tg(2), 0, 1, tg(20), 16'h0420, 0, "R4");
    step(1, tg(3), 0, 0, 16'h0, 16'h0, 0, "R4");
    step(1, tg(20), 0, 0, 16'h0, 16'h0, 0, "R4");
    step(1, tg(20), 2, 0, 16'h0, 16'h0, 1, "R4");
    // R6: rewrite a held tag
    step(0, 16'h0, 0, 1, tg(5), 16'hBEEF, 1, "R6");
    idle("R6");
    step(1, tg(5), 1, 0, 16'h0, 16'h0, 1, "R6");
    // R9: back-to-back same tag, new and held
    step(0, 16'h0, 0, 1, tg(30), 16'h3001, 1, "R9");
    step(0, 16'h0, 0, 1, tg(30), 16'h3002, 1, "R9");
    idle("R9");
    step(1, tg(30), 4, 0, 16'h0, 16'h0, 1, "R9");
    step(0, 16'h0, 0, 1, tg(6), 16'h6001, 1, "R9");
    step(0, 16'h0, 0, 1, tg(6), 16'h6002, 1, "R9");
    step(0, 16'h0, 0, 1, tg(6), 16'h6003, 1, "R9");
    idle("R9");
    step(1, tg(6), 0, 0, 16'h0, 16'h0, 1, "R9");
    // R8/R11/R7: evictions with lookup hits and same-cycle updates
    for (int k = 0; k < 24; k++) begin
      step(1, tg((k * 3) % 12), k, 1, tg(40 + k), 16'(16'h7000 + k), 1, "R11");
      step(1, tg(40 + k), k, 0, 16'h0, 16'h0, 1, "R8");
    end
    // R7: sweep all tags ever used
    for (int i = 0; i < 64; i++) step(1, tg(i), i, 0, 16'h0, 16'h0, 1, "R7");
    idle("R10");
    // R1: reset clears everything
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < N; i++) mval[i] = 0;
    mtree = '0; p_v = 0; p_hit = 0; m_meta = '0;
    step(1, tg(40), 0, 0, 16'h0, 16'h0, 1, "R1");
    step(1, tg(1), 0, 0, 16'h0, 16'h0, 1, "R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule